// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block is a 256-byte data cache that sits between a 32-bit processor port and main memory. Storage is organised as eight sets. Each set has two ways, and every way holds a four-word line together with a tag, a valid flag and a dirty flag. One replacement bit per set records which way was used least recently. For each access, the tags of both ways in the indexed set are compared in parallel. On a hit, a read returns the word and a store merges its enabled bytes into the line. Main memory is not touched on a hit.

On a miss, the requester is held stalled and a victim way is chosen. If the victim holds modified data, its four words are first sent to memory through a burst write channel. The missing line is then fetched through a burst read channel. After the refill, the access goes through the compare stage again and completes as an ordinary hit. A store that misses therefore allocates the line, merges its bytes and marks the line dirty. A line that has just been filled starts out clean.

The processor raises a request and holds its address, direction, byte enables and store data until `cpu_ready` is seen. It then drops or replaces the request on the following cycle.

Top module: `cache2w_top`

## Requirements
- R1: Both ways of the indexed set are compared at the same time, and at most one of them can match. A read hit returns the stored word. On a hit, `cpu_ready` is high during the cycle that follows the clock edge at which the request was accepted.
- R2: The byte address is split into four fields. Bits [31:7] are the tag, bits [6:4] select the set, bits [3:2] select the word in the line, and bits [1:0] select the byte. A line occupies the 16 bytes that start at `{tag, set, 4'b0000}`.
- R3: A store hit changes only the bytes whose `cpu_be` bit is 1 (bit i controls data bits [8i+7:8i]). It marks the line dirty and does not write memory. A store with `cpu_be` = 4'b0000 leaves the word unchanged.
- R4: On a miss, `cpu_ready` stays low while exactly one burst read fetches the four words of the line, starting at the line base, with the first data beat going to word 0. The access then completes as a hit.
- R5: If a way of the indexed set is invalid, the miss fills an invalid way before it evicts any valid line. Way 0 is filled before way 1.
- R6: When both ways of a set are valid, the victim is the least recently used way. Every hit and every fill makes the set's replacement bit point at the way that was not just used.
- R7: If the victim is dirty, its four words are written to memory before the burst read starts. The write address is built from the victim's tag and the set index, and the words are written in word order 0 to 3. A clean victim is not written.
- R8: A store miss first allocates and refills the line, then merges the store bytes and marks the line dirty. A line that has just been refilled is clean.
- R9: Reset clears every valid bit, dirty bit and replacement bit. After reset, every access misses, no write-back is issued, and `cpu_ready`, `mem_rd_req` and `mem_wr_req` are all low.
- R10: `mem_rd_req` stays high from the start of a refill until four beats marked by `mem_rd_valid` have been taken. During a write-back, `mem_wr_req` is high, the beat address and data are held stable, and the beat moves on only when `mem_wr_ready` is high. The read channel and the write channel are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_be | input | 4 | Byte enables for a store |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ready` is high on a load |
| cpu_ready | output | 1 | Access completes in this cycle |
| mem_rd_req | output | 1 | Burst line read in progress |
| mem_rd_addr | output | 32 | Line base address of the burst read |
| mem_rd_valid | input | 1 | One read beat is present on `mem_rd_data` |
| mem_rd_data | input | 32 | Read beat data |
| mem_wr_req | output | 1 | Write-back beat is offered |
| mem_wr_addr | output | 32 | Word address of the offered write beat |
| mem_wr_data | output | 32 | Data of the offered write beat |
| mem_wr_ready | input | 1 | Memory takes the offered write beat |

## Verification
The situation that is hardest to reach from the ports is the eviction of a dirty line from a full set. To get there, the stimulus has to fill both ways of one set, store into one of them, and then steer the replacement bit with hits so that the dirty way becomes least recently used before a third tag arrives. The vector table plays such sequences against set 1 with three tags that collide there. It predicts from its own replacement model which misses must write back, and it checks the written words against its model of the processor-visible memory. The bench then reads the evicted address again, so the refill must return the merged store bytes from memory.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int LINE_WORDS = 4;
  localparam int NUM_SETS   = 8;
  localparam int NUM_WAYS   = 2;   // one replacement bit per set assumes two ways

  localparam int BE_W    = DATA_W / 8;
  localparam int BOFF_W  = $clog2(BE_W);
  localparam int WORD_W  = $clog2(LINE_WORDS);
  localparam int SET_W   = $clog2(NUM_SETS);
  localparam int WAY_W   = $clog2(NUM_WAYS);
  localparam int TAG_W   = ADDR_W - SET_W - WORD_W - BOFF_W;
  localparam int ENTRIES = NUM_WAYS * NUM_SETS * LINE_WORDS;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [SET_W-1:0]  set_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [WAY_W-1:0]  way_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [BE_W-1:0]   be_t;

  typedef enum logic [1:0] {ST_IDLE, ST_CMP, ST_WBACK, ST_FILL} cstate_e;

  function automatic tag_t addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic set_t addr_set(input logic [ADDR_W-1:0] a);
    return a[BOFF_W+WORD_W +: SET_W];
  endfunction

  function automatic word_t addr_word(input logic [ADDR_W-1:0] a);
    return a[BOFF_W +: WORD_W];
  endfunction

  function automatic logic [ADDR_W-1:0] beat_addr(input tag_t t, input set_t s, input word_t w);
    return {t, s, w, {BOFF_W{1'b0}}};
  endfunction

  function automatic data_t merge_bytes(input data_t old_w, input data_t new_w, input be_t be);
    data_t r;
    for (int b = 0; b < BE_W; b++)
      r[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cache2w_tags.sv
module cache2w_tags
  import cache2w_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  set_t                 lk_set,
  input  tag_t                 lk_tag,
  output logic [NUM_WAYS-1:0]  way_match,
  output logic [NUM_WAYS-1:0]  way_valid,
  output logic [NUM_WAYS-1:0]  way_dirty,
  output tag_t [NUM_WAYS-1:0]  way_tag,
  output logic                 lru_way,
  input  logic                 fill_en,
  input  way_t                 fill_way,
  input  tag_t                 fill_tag,
  input  logic                 dirty_en,
  input  way_t                 dirty_way,
  input  logic                 touch_en,
  input  way_t                 touch_way
);
  logic [NUM_SETS-1:0] lru_q;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [NUM_SETS-1:0] valid_q;
    logic [NUM_SETS-1:0] dirty_q;
    tag_t                tag_q [NUM_SETS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else if (fill_en && fill_way == way_t'(w)) begin
        valid_q[lk_set] <= 1'b1;
        dirty_q[lk_set] <= 1'b0;
        tag_q[lk_set]   <= fill_tag;
      end else if (dirty_en && dirty_way == way_t'(w)) begin
        dirty_q[lk_set] <= 1'b1;
      end
    end

    assign way_valid[w] = valid_q[lk_set];
    assign way_dirty[w] = dirty_q[lk_set];
    assign way_tag[w]   = tag_q[lk_set];
    assign way_match[w] = valid_q[lk_set] && (tag_q[lk_set] == lk_tag);

    p_fill_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && fill_way == way_t'(w)) |=> (valid_q[$past(lk_set)] && !dirty_q[$past(lk_set)]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        lru_q <= '0;
    else if (touch_en) lru_q[lk_set] <= ~touch_way;
  end

  assign lru_way = lru_q[lk_set];

  p_single_match_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(way_match));
  p_lru_away_r6: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (lru_q[$past(lk_set)] != $past(touch_way)));
endmodule

// File: rtl/cache2w_data.sv
module cache2w_data
  import cache2w_pkg::*;
(
  input  logic  clk,
  input  way_t  rd_way,
  input  set_t  rd_set,
  input  word_t rd_word,
  output data_t rd_data,
  input  logic  wr_en,
  input  way_t  wr_way,
  input  set_t  wr_set,
  input  word_t wr_word,
  input  data_t wr_data
);
  localparam int IDX_W = WAY_W + SET_W + WORD_W;

  data_t mem_q [ENTRIES];

  function automatic int unsigned slot(input way_t w, input set_t s, input word_t d);
    logic [IDX_W-1:0] i;
    i = {w, s, d};
    return int'(i);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[slot(wr_way, wr_set, wr_word)] <= wr_data;
  end

  assign rd_data = mem_q[slot(rd_way, rd_set, rd_word)];
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                cpu_we,
  input  be_t                 cpu_be,
  input  data_t               cpu_wdata,
  output logic                cpu_ready,
  output set_t                lk_set,
  output tag_t                lk_tag,
  input  logic [NUM_WAYS-1:0] way_match,
  input  logic [NUM_WAYS-1:0] way_valid,
  input  logic [NUM_WAYS-1:0] way_dirty,
  input  tag_t [NUM_WAYS-1:0] way_tag,
  input  logic                lru_way,
  output logic                fill_en,
  output way_t                fill_way,
  output logic                dirty_en,
  output logic                touch_en,
  output way_t                touch_way,
  output way_t                rd_way,
  output word_t               rd_word,
  input  data_t               rd_data,
  output logic                wr_en,
  output way_t                wr_way,
  output word_t               wr_word,
  output data_t               wr_data,
  output logic                mem_rd_req,
  output logic [ADDR_W-1:0]   mem_rd_addr,
  input  logic                mem_rd_valid,
  input  data_t               mem_rd_data,
  output logic                mem_wr_req,
  output logic [ADDR_W-1:0]   mem_wr_addr,
  output data_t               mem_wr_data,
  input  logic                mem_wr_ready
);
  localparam word_t LAST_BEAT = word_t'(LINE_WORDS - 1);

  cstate_e             state_q, state_d;
  logic [ADDR_W-1:0]   addr_q;
  logic                we_q;
  be_t                 be_q;
  data_t               wdata_q;
  word_t               beat_q;
  way_t                victim_q;

  // named internal events
  logic  hit_w, hit_evt, miss_evt, victim_dirty;
  logic  wb_beat_evt, wb_last, fill_beat_evt, fill_last;
  way_t  hit_way, victim_pick;
  word_t req_word;

  assign lk_set   = addr_set(addr_q);
  assign lk_tag   = addr_tag(addr_q);
  assign req_word = addr_word(addr_q);

  assign hit_w    = |way_match;
  assign hit_way  = way_t'(way_match[1]);
  assign hit_evt  = (state_q == ST_CMP) && hit_w;
  assign miss_evt = (state_q == ST_CMP) && !hit_w;

  always_comb begin
    if (!way_valid[0])      victim_pick = way_t'(0);
    else if (!way_valid[1]) victim_pick = way_t'(1);
    else                    victim_pick = way_t'(lru_way);
  end
  assign victim_dirty = way_valid[victim_pick] && way_dirty[victim_pick];

  assign wb_beat_evt   = (state_q == ST_WBACK) && mem_wr_ready;
  assign wb_last       = wb_beat_evt && (beat_q == LAST_BEAT);
  assign fill_beat_evt = (state_q == ST_FILL) && mem_rd_valid;
  assign fill_last     = fill_beat_evt && (beat_q == LAST_BEAT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cpu_req) state_d = ST_CMP;
      ST_CMP:   if (hit_w) state_d = ST_IDLE;
                else       state_d = victim_dirty ? ST_WBACK : ST_FILL;
      ST_WBACK: if (wb_last) state_d = ST_FILL;
      ST_FILL:  if (fill_last) state_d = ST_CMP;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      beat_q   <= '0;
      victim_q <= '0;
      addr_q   <= '0;
      we_q     <= 1'b0;
      be_q     <= '0;
      wdata_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cpu_req) begin
        addr_q  <= cpu_addr;
        we_q    <= cpu_we;
        be_q    <= cpu_be;
        wdata_q <= cpu_wdata;
      end
      if (miss_evt) begin
        victim_q <= victim_pick;
        beat_q   <= '0;
      end else if (wb_beat_evt || fill_beat_evt) begin
        beat_q <= beat_q + word_t'(1);
      end
    end
  end

  // processor side
  assign cpu_ready = hit_evt;

  // data array access
  assign rd_way  = (state_q == ST_WBACK) ? victim_q : hit_way;
  assign rd_word = (state_q == ST_WBACK) ? beat_q : req_word;
  assign wr_en   = (hit_evt && we_q) || fill_beat_evt;
  assign wr_way  = fill_beat_evt ? victim_q : hit_way;
  assign wr_word = fill_beat_evt ? beat_q : req_word;
  assign wr_data = fill_beat_evt ? mem_rd_data : merge_bytes(rd_data, wdata_q, be_q);

  // tag array updates
  assign fill_en   = fill_last;
  assign fill_way  = victim_q;
  assign dirty_en  = hit_evt && we_q;
  assign touch_en  = hit_evt || fill_last;
  assign touch_way = fill_last ? victim_q : hit_way;

  // memory side
  assign mem_wr_req  = (state_q == ST_WBACK);
  assign mem_wr_addr = beat_addr(way_tag[victim_q], lk_set, beat_q);
  assign mem_wr_data = rd_data;
  assign mem_rd_req  = (state_q == ST_FILL);
  assign mem_rd_addr = beat_addr(lk_tag, lk_set, '0);

  p_dirty_wb_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && victim_dirty) |=> (mem_wr_req && !mem_rd_req));
  p_clean_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && !victim_dirty) |=> (mem_rd_req && !mem_wr_req));
  p_invalid_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && !way_valid[0]) |=> (victim_q == way_t'(0)));
  p_lru_victim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && (&way_valid)) |=> (victim_q == way_t'($past(lru_way))));
  p_fill_then_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |=> hit_evt);
  p_store_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_evt && we_q) |=> !mem_wr_req);
  p_rd_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> mem_rd_req);
  p_wr_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ready) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));
  p_one_channel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_req && mem_rd_req));
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
  import cache2w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [BE_W-1:0]   cpu_be,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ready
);
  set_t                lk_set;
  tag_t                lk_tag;
  logic [NUM_WAYS-1:0] way_match, way_valid, way_dirty;
  tag_t [NUM_WAYS-1:0] way_tag;
  logic                lru_way;
  logic                fill_en, dirty_en, touch_en, wr_en;
  way_t                fill_way, touch_way, rd_way, wr_way;
  word_t               rd_word, wr_word;
  data_t               rd_data, wr_data;

  cache2w_ctrl u_ctrl (
    .clk, .rst_n, .cpu_req, .cpu_addr, .cpu_we, .cpu_be, .cpu_wdata, .cpu_ready,
    .lk_set, .lk_tag, .way_match, .way_valid, .way_dirty, .way_tag, .lru_way,
    .fill_en, .fill_way, .dirty_en, .touch_en, .touch_way,
    .rd_way, .rd_word, .rd_data, .wr_en, .wr_way, .wr_word, .wr_data,
    .mem_rd_req, .mem_rd_addr, .mem_rd_valid, .mem_rd_data,
    .mem_wr_req, .mem_wr_addr, .mem_wr_data, .mem_wr_ready
  );

  cache2w_tags u_tags (
    .clk, .rst_n, .lk_set, .lk_tag, .way_match, .way_valid, .way_dirty, .way_tag,
    .lru_way, .fill_en, .fill_way, .fill_tag(lk_tag), .dirty_en, .dirty_way(wr_way),
    .touch_en, .touch_way
  );

  cache2w_data u_data (
    .clk, .rd_way, .rd_set(lk_set), .rd_word, .rd_data,
    .wr_en, .wr_way, .wr_set(lk_set), .wr_word, .wr_data
  );

  assign cpu_rdata = rd_data;
endmodule

// File: tb/cache2w_top_test.sv
module cache2w_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_rd_req, mem_wr_req;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic        mem_rd_valid = 1'b0, mem_wr_ready = 1'b0;
  logic [31:0] mem_rd_data = '0;

  always #5 clk = ~clk;

  cache2w_top uut (.*);

  int n_checks = 0, n_errors = 0;
  logic [31:0] backing [logic [31:0]];   // memory behind the cache
  logic [31:0] visible [logic [31:0]];   // value the processor should see

  function automatic logic [31:0] init_word(input logic [31:0] a);
    return (a << 16) ^ a ^ 32'h5A5A_0000;
  endfunction
  function automatic logic [31:0] back_get(input logic [31:0] a);
    return backing.exists(a) ? backing[a] : init_word(a);
  endfunction
  function automatic logic [31:0] vis_get(input logic [31:0] a);
    return visible.exists(a) ? visible[a] : back_get(a);
  endfunction
  function automatic logic [31:0] bytes_in(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] m;
    m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return (n & m) | (o & ~m);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-access monitor state
  int          wb_beats, rd_bursts, wb_at_rd, both_busy;
  logic        rd_seen = 1'b0;
  logic [31:0] cur_addr;

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_rd_req && mem_wr_req) both_busy++;
      if (mem_wr_req && mem_wr_ready) begin
        check(mem_wr_data == vis_get(mem_wr_addr), "R7 write-back data", mem_wr_data, vis_get(mem_wr_addr));
        check(mem_wr_addr[3:2] == 2'(wb_beats), "R7 write-back order", {30'd0, mem_wr_addr[3:2]}, wb_beats);
        backing[mem_wr_addr] = mem_wr_data;
        wb_beats++;
      end
      if (mem_rd_req && !rd_seen) begin
        rd_seen = 1'b1;
        rd_bursts++;
        wb_at_rd = wb_beats;
        check(mem_rd_addr == (cur_addr & ~32'hF), "R2 refill line base", mem_rd_addr, cur_addr & ~32'hF);
      end
      if (!mem_rd_req) rd_seen = 1'b0;
    end
  end

  // memory model: responses change on the falling edge
  logic        rd_busy = 1'b0;
  int          rd_wait, rd_beat;
  logic [31:0] rd_base;
  always @(negedge clk) begin
    mem_wr_ready <= mem_wr_req ? ~mem_wr_ready : 1'b0;
    if (!rd_busy) begin
      mem_rd_valid <= 1'b0;
      if (mem_rd_req) begin
        rd_busy = 1'b1; rd_wait = 2; rd_beat = 0; rd_base = mem_rd_addr;
      end
    end else if (rd_wait > 0) begin
      rd_wait--;
      mem_rd_valid <= 1'b0;
    end else if (rd_beat < 4) begin
      mem_rd_valid <= 1'b1;
      mem_rd_data  <= back_get(rd_base + 32'(4 * rd_beat));
      rd_beat++;
    end else begin
      mem_rd_valid <= 1'b0;
      if (!mem_rd_req) rd_busy = 1'b0;
    end
  end

  task automatic access(input logic we, input logic [3:0] be, input logic [31:0] a,
                        input logic [31:0] d, output int lat, output logic [31:0] rd);
    @(negedge clk);
    wb_beats = 0; rd_bursts = 0; wb_at_rd = -1; cur_addr = a;
    cpu_req = 1'b1; cpu_we = we; cpu_be = be; cpu_addr = a; cpu_wdata = d;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!cpu_ready && lat < 400);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    if (we) visible[a & ~32'h3] = bytes_in(vis_get(a & ~32'h3), d, be);
  endtask

  // we, be, addr, wdata, expect hit, expected write-back beats
  localparam int NV = 16;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 4'hF, 32'h0000_0010, 32'h0,         1'b0, 3'd0},
    {1'b0, 4'hF, 32'h0000_0014, 32'h0,         1'b1, 3'd0},
    {1'b1, 4'h3, 32'h0000_0018, 32'h1234_5678, 1'b1, 3'd0},
    {1'b0, 4'hF, 32'h0000_0018, 32'h0,         1'b1, 3'd0},
    {1'b0, 4'hF, 32'h0000_0090, 32'h0,         1'b0, 3'd0},
    {1'b0, 4'hF, 32'h0000_0010, 32'h0,         1'b1, 3'd0},
    {1'b0, 4'hF, 32'h0000_0110, 32'h0,         1'b0, 3'd0},
    {1'b0, 4'hF, 32'h0000_009C, 32'h0,         1'b0, 3'd4},
    {1'b0, 4'hF, 32'h0000_0018, 32'h0,         1'b0, 3'd0},
    {1'b1, 4'h8, 32'h0000_0224, 32'hAB00_0000, 1'b0, 3'd0},
    {1'b0, 4'hF, 32'h0000_0224, 32'h0,         1'b1, 3'd0},
    {1'b0, 4'hF, 32'h0000_0220, 32'h0,         1'b1, 3'd0},
    {1'b1, 4'h6, 32'h0000_0114, 32'h00CD_EF00, 1'b0, 3'd0},
    {1'b0, 4'hF, 32'h0000_0090, 32'h0,         1'b0, 3'd0},
    {1'b0, 4'hF, 32'h0000_0010, 32'h0,         1'b0, 3'd4},
    {1'b0, 4'hF, 32'h0000_0114, 32'h0,         1'b0, 3'd0}
  };

  initial begin
    int lat;
    logic [31:0] rd, a;
    both_busy = 0; wb_beats = 0; rd_bursts = 0; wb_at_rd = -1; cur_addr = '0;
    repeat (3) @(negedge clk);
    check(!cpu_ready && !mem_rd_req && !mem_wr_req, "R9 outputs idle in reset",
          {29'd0, cpu_ready, mem_rd_req, mem_wr_req}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [72:0] v;
      v = VEC[i];
      a = v[67:36];
      access(v[72], v[71:68], a, v[35:4], lat, rd);
      if (v[3]) check(lat == 1, "R1 hit latency", lat, 1);
      else      check(lat > 1 && rd_bursts == 1, "R4 miss stalls for one refill", lat, 2);
      if (!v[3]) check(wb_at_rd == int'(v[2:0]), "R7 write-back beats before refill", wb_at_rd, v[2:0]);
      check(wb_beats == int'(v[2:0]), v[72] ? "R3 store causes no extra write" : "R6 replacement write-backs",
            wb_beats, v[2:0]);
      if (!v[72]) check(rd == vis_get(a), v[3] ? "R1 read hit data" : "R8 data after refill", rd, vis_get(a));
    end

    // R8: a freshly allocated store line becomes dirty, so its eviction writes back
    access(1'b0, 4'hF, 32'h0000_02A0, 0, lat, rd);
    access(1'b0, 4'hF, 32'h0000_0324, 0, lat, rd);
    check(wb_beats == 4 && backing.exists(32'h224), "R8 store miss line written back", wb_beats, 4);
    check(back_get(32'h224) == visible[32'h224], "R8 merged bytes reached memory", back_get(32'h224), visible[32'h224]);

    // R3: empty byte enables leave the word unchanged
    access(1'b0, 4'hF, 32'h0000_0018, 0, lat, rd);
    access(1'b1, 4'h0, 32'h0000_0018, 32'hFFFF_FFFF, lat, rd);
    check(lat == 1, "R3 empty-enable store hits", lat, 1);
    access(1'b0, 4'hF, 32'h0000_0018, 0, lat, rd);
    check(rd == vis_get(32'h18), "R3 empty-enable store unchanged", rd, vis_get(32'h18));
    access(1'b1, 4'h4, 32'h0000_0018, 32'h0077_0000, lat, rd);
    access(1'b0, 4'hF, 32'h0000_0018, 0, lat, rd);
    check(rd == vis_get(32'h18) && wb_beats == 0, "R3 single byte store", rd, vis_get(32'h18));

    // R9: reset drops cached contents, dirty data is lost without write-back
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!cpu_ready && !mem_rd_req && !mem_wr_req, "R9 outputs idle after reset",
          {29'd0, cpu_ready, mem_rd_req, mem_wr_req}, 32'd0);
    rst_n = 1'b1;
    visible.delete();
    access(1'b0, 4'hF, 32'h0000_0018, 0, lat, rd);
    check(lat > 1 && wb_beats == 0, "R9 miss after reset without write-back", lat, 2);
    check(rd == back_get(32'h18), "R9 data from memory after reset", rd, back_get(32'h18));
    access(1'b0, 4'hF, 32'h0000_0094, 0, lat, rd);
    check(lat > 1 && wb_beats == 0, "R5 second line fills free way", lat, 2);
    access(1'b0, 4'hF, 32'h0000_0010, 0, lat, rd);
    check(lat == 1, "R5 first line kept", lat, 1);
    access(1'b0, 4'hF, 32'h0000_0090, 0, lat, rd);
    check(lat == 1, "R5 second line kept", lat, 1);

    check(both_busy == 0, "R10 channels never both requested", both_busy, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule